// File: doc/BRIEF.md
# Floating Bus Presence Detector

This block decides, before any reset or identification is attempted, whether a disk-interface channel has nothing attached and its data lines simply float high. It is started by a one-cycle `start` pulse and works through a single-outstanding register access port. It first polls the channel's status register and ORs every value it reads into an accumulator that begins at zero. ORing the samples means that a status line which flickers still adds up to a stable verdict. If the busy bit of the accumulated value is low after a read, something is driving the bus and the channel is reported as occupied. If the window (counted in millisecond tick pulses) runs out before every bit has been seen high, the channel is also reported as occupied.

If the accumulator ever reaches all ones, the block moves on to a confirmation step. It writes three distinct patterns into three task-file registers and reads them back. When all three come back intact, real registers exist and the channel is reported as occupied. Any mismatch marks the channel as floating. The result appears as a one-cycle `done` pulse. `floating` is valid from that pulse until the next accepted start.

The register port is a request channel with valid/ready. A request (read or write, address, write data) is held unchanged while `reg_req_valid` is high and `reg_req_ready` is low. It transfers on the cycle where both are high. Each accepted read is answered later by exactly one `reg_rsp_valid` cycle carrying the data. The block never has more than one read outstanding and it always accepts the response, so the response side has no back-pressure. Writes produce no response.

Top module: `fbd_float_detect`

## Requirements
- R1: After reset `done`, `floating` and `reg_req_valid` are all low, and the block issues no request until a start is accepted.
- R2: `start` is accepted only while the block is idle. A start pulse during a detection has no effect: it neither restarts the tick window nor changes the result or its timing.
- R3: During sampling the block issues reads of the status register (address 7) one at a time and ORs each returned byte into an accumulator that is cleared when a start is accepted. Exactly one status read is made per decision step.
- R4: If, after a status read, bit 7 (busy) of the accumulator is 0, the detection ends with `floating` = 0. No register write is issued.
- R5: If, after a status read, the accumulator equals 0xFF, the block enters confirmation at once. This outcome takes precedence over an expired window.
- R6: The window expires once WINDOW_TICKS `tick` pulses have been counted since the start was accepted. The first status read that completes after expiry without reaching 0xFF ends the detection with `floating` = 0. No read ends the detection on expiry grounds before that count is reached.
- R7: Confirmation issues exactly three writes, in this order: 0xAA to address 2, 0x55 to address 3, 0xFF to address 4. It then reads addresses 2, 3 and 4 in that order.
- R8: If all three read-back values equal the written patterns, `floating` = 0. If any of them differs, `floating` = 1.
- R9: `done` is high for exactly one cycle per detection, in the cycle after the final response. `floating` keeps its value until the next accepted start and is cleared in the cycle after that start.
- R10: While `reg_req_valid` is high and `reg_req_ready` is low, the request fields stay stable and `reg_req_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run a detection |
| tick | input | 1 | Millisecond tick pulse for the sampling window |
| reg_req_valid | output | 1 | Register request valid |
| reg_req_ready | input | 1 | Register request accepted when high with valid |
| reg_req_write | output | 1 | 1 = write, 0 = read |
| reg_req_addr | output | ADDR_W | Register address |
| reg_req_wdata | output | DATA_W | Write data |
| reg_rsp_valid | input | 1 | Read data valid, one cycle per accepted read |
| reg_rsp_rdata | input | DATA_W | Read data |
| done | output | 1 | One-cycle completion pulse |
| floating | output | 1 | 1 = bus judged floating; valid from done until next start |

## Verification
The bench builds the block with WINDOW_TICKS set to 4 and keeps the default 8-bit data and 3-bit addresses. With that setting the window edge is reached after a handful of tick pulses, so the bench can stop one tick short and watch that no verdict appears. It can then add the last tick and see the verdict come out. The short window also makes it cheap to expire the window while a status read is still pending, which shows that an all-ones accumulator beats expiry. Random ready stalls and random response latency run against a register model that either echoes writes, ignores all writes and reads 0xFF, or has one register stuck.

// File: rtl/fbd_pkg.sv
package fbd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STAT_REQ,
    ST_STAT_WAIT,
    ST_PROBE_WR,
    ST_PROBE_RD,
    ST_PROBE_WAIT
  } fbd_state_e;

endpackage

// File: rtl/fbd_window.sv
module fbd_window #(
  parameter int unsigned WINDOW_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int unsigned CW = $clog2(WINDOW_TICKS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (clear)                   cnt_q <= '0;
    else if (run && tick && !expired) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q >= CW'(WINDOW_TICKS));

  // once expired the window stays expired until the next clear
  p_window_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clear) |=> expired);

endmodule

// File: rtl/fbd_accum.sv
module fbd_accum #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned BUSY_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic              full_now,
  output logic              busy_low_now,
  output logic              acc_full
);
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] acc_nxt;

  assign acc_nxt      = acc_q | din;
  assign full_now     = load && (&acc_nxt);
  assign busy_low_now = load && !acc_nxt[BUSY_BIT];
  assign acc_full     = &acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else if (load)  acc_q <= acc_nxt;
  end

  // bits can only be gained between clears
  p_acc_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((acc_q & $past(acc_q)) == $past(acc_q)));

endmodule

// File: rtl/fbd_probe.sv
module fbd_probe #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned BASE    = 2,
  parameter int unsigned PROBE_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              clr_mm,
  input  logic              step,
  input  logic              cmp_en,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] pattern,
  output logic              last,
  output logic              mismatch_final
);
  localparam int unsigned IW = (PROBE_N > 1) ? $clog2(PROBE_N) : 1;

  logic [IW-1:0] idx_q;
  logic          mm_q;
  logic          miss;

  function automatic logic [DATA_W-1:0] pat_of(input logic [IW-1:0] i);
    logic [DATA_W-1:0] p;
    if (i == IW'(0))      p = {(DATA_W/2){2'b10}};
    else if (i == IW'(1)) p = {(DATA_W/2){2'b01}};
    else                  p = '1;
    return p;
  endfunction

  assign pattern        = pat_of(idx_q);
  assign addr           = ADDR_W'(BASE) + ADDR_W'(idx_q);
  assign last           = (idx_q == IW'(PROBE_N - 1));
  assign miss           = cmp_en && (rdata != pattern);
  assign mismatch_final = mm_q || miss;

  always_ff @(posedge clk) begin
    if (!rst_n)       idx_q <= '0;
    else if (restart) idx_q <= '0;
    else if (step)    idx_q <= idx_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      mm_q <= 1'b0;
    else if (clr_mm) mm_q <= 1'b0;
    else if (miss)   mm_q <= 1'b1;
  end

  p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IW'(PROBE_N - 1));

endmodule

// File: rtl/fbd_float_detect.sv
module fbd_float_detect
  import fbd_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned ADDR_W       = 3,
  parameter int unsigned STATUS_ADDR  = 7,
  parameter int unsigned BUSY_BIT     = 7,
  parameter int unsigned PROBE_BASE   = 2,
  parameter int unsigned PROBE_N      = 3,
  parameter int unsigned WINDOW_TICKS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  output logic              reg_req_valid,
  input  logic              reg_req_ready,
  output logic              reg_req_write,
  output logic [ADDR_W-1:0] reg_req_addr,
  output logic [DATA_W-1:0] reg_req_wdata,
  input  logic              reg_rsp_valid,
  input  logic [DATA_W-1:0] reg_rsp_rdata,
  output logic              done,
  output logic              floating
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

  fbd_state_e state_q, state_d;
  logic done_q, float_q;

  logic win_clear, win_run, expired;
  logic acc_clear, acc_load, full_now, busy_low_now, acc_full;
  logic pr_restart, pr_clrmm, pr_step, pr_cmp, pr_last, mm_final;
  logic [ADDR_W-1:0] pr_addr;
  logic [DATA_W-1:0] pr_pat;
  logic fin, fin_val;

  assign win_run = (state_q == ST_STAT_REQ) || (state_q == ST_STAT_WAIT);

  fbd_window #(.WINDOW_TICKS(WINDOW_TICKS)) u_window (
    .clk(clk), .rst_n(rst_n), .clear(win_clear), .run(win_run),
    .tick(tick), .expired(expired)
  );

  fbd_accum #(.DATA_W(DATA_W), .BUSY_BIT(BUSY_BIT)) u_accum (
    .clk(clk), .rst_n(rst_n), .clear(acc_clear), .load(acc_load),
    .din(reg_rsp_rdata), .full_now(full_now), .busy_low_now(busy_low_now),
    .acc_full(acc_full)
  );

  fbd_probe #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE(PROBE_BASE),
              .PROBE_N(PROBE_N)) u_probe (
    .clk(clk), .rst_n(rst_n), .restart(pr_restart), .clr_mm(pr_clrmm),
    .step(pr_step), .cmp_en(pr_cmp), .rdata(reg_rsp_rdata),
    .addr(pr_addr), .pattern(pr_pat), .last(pr_last),
    .mismatch_final(mm_final)
  );

  always_comb begin
    state_d       = state_q;
    reg_req_valid = 1'b0;
    reg_req_write = 1'b0;
    reg_req_addr  = STAT_A;
    reg_req_wdata = '0;
    win_clear     = 1'b0;
    acc_clear     = 1'b0;
    acc_load      = 1'b0;
    pr_restart    = 1'b0;
    pr_clrmm      = 1'b0;
    pr_step       = 1'b0;
    pr_cmp        = 1'b0;
    fin           = 1'b0;
    fin_val       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          win_clear = 1'b1;
          acc_clear = 1'b1;
          state_d   = ST_STAT_REQ;
        end
      end
      ST_STAT_REQ: begin
        reg_req_valid = 1'b1;
        if (reg_req_ready) state_d = ST_STAT_WAIT;
      end
      ST_STAT_WAIT: begin
        if (reg_rsp_valid) begin
          acc_load = 1'b1;
          if (full_now) begin
            pr_restart = 1'b1;
            pr_clrmm   = 1'b1;
            state_d    = ST_PROBE_WR;
          end else if (busy_low_now || expired) begin
            fin     = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_STAT_REQ;
          end
        end
      end
      ST_PROBE_WR: begin
        reg_req_valid = 1'b1;
        reg_req_write = 1'b1;
        reg_req_addr  = pr_addr;
        reg_req_wdata = pr_pat;
        if (reg_req_ready) begin
          if (pr_last) begin
            pr_restart = 1'b1;
            state_d    = ST_PROBE_RD;
          end else begin
            pr_step = 1'b1;
          end
        end
      end
      ST_PROBE_RD: begin
        reg_req_valid = 1'b1;
        reg_req_addr  = pr_addr;
        if (reg_req_ready) state_d = ST_PROBE_WAIT;
      end
      ST_PROBE_WAIT: begin
        if (reg_rsp_valid) begin
          pr_cmp = 1'b1;
          if (pr_last) begin
            fin     = 1'b1;
            fin_val = mm_final;
            state_d = ST_IDLE;
          end else begin
            pr_step = 1'b1;
            state_d = ST_PROBE_RD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      float_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (state_q == ST_IDLE && start) float_q <= 1'b0;
      else if (fin)                    float_q <= fin_val;
    end
  end

  assign done     = done_q;
  assign floating = float_q;

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start) |=> !reg_req_valid);

  p_busy_no_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> !floating);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req_valid && !reg_req_ready) |=>
      (reg_req_valid && $stable(reg_req_write) && $stable(reg_req_addr)
       && $stable(reg_req_wdata)));

  p_write_needs_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req_valid && reg_req_write) |-> acc_full);

  p_status_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req_valid && state_q == ST_STAT_REQ) |->
      (!reg_req_write && reg_req_addr == STAT_A));

endmodule

// File: tb/tb_fbd_float_detect.sv
module tb_fbd_float_detect;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, tick = 1'b0;
  logic req_valid, req_ready = 1'b0, req_write;
  logic [2:0] req_addr;
  logic [7:0] req_wdata;
  logic rsp_valid = 1'b0;
  logic [7:0] rsp_rdata = 8'h00;
  logic done, floating;

  always #2 clk = ~clk;

  fbd_float_detect #(.WINDOW_TICKS(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .reg_req_valid(req_valid), .reg_req_ready(req_ready),
    .reg_req_write(req_write), .reg_req_addr(req_addr),
    .reg_req_wdata(req_wdata), .reg_rsp_valid(rsp_valid),
    .reg_rsp_rdata(rsp_rdata), .done(done), .floating(floating)
  );

  int checks = 0, errors = 0;
  logic [7:0] st_seq [8];
  int st_len = 1, mode = 0, first_lat = 0;
  int stat_rd = 0, wr_cnt = 0, done_cnt = 0;
  logic last_float = 1'b0;
  logic [2:0] wr_a [8];
  logic [7:0] wr_d [8];
  logic [7:0] dev_reg [8];
  int hold_viol = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // device model and monitor
  initial begin
    bit pend = 0;
    int pcnt = 0;
    logic [7:0] pdata = 0;
    bit stalled = 0;
    logic [11:0] held = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (pend) begin
        if (pcnt == 0) begin
          rsp_valid = 1'b1; rsp_rdata = pdata; pend = 0;
        end else pcnt--;
      end
      if (done) begin done_cnt++; last_float = floating; end
      if (stalled && (!req_valid || {req_write, req_addr, req_wdata} != held))
        hold_viol++;
      req_ready = ($urandom % 4) != 0;
      stalled = req_valid && !req_ready;
      held = {req_write, req_addr, req_wdata};
      if (req_valid && req_ready) begin
        if (req_write) begin
          if (wr_cnt < 8) begin wr_a[wr_cnt] = req_addr; wr_d[wr_cnt] = req_wdata; end
          wr_cnt++;
          if (mode == 0 || (mode == 2 && req_addr != 3'd3)) dev_reg[req_addr] = req_wdata;
        end else begin
          pend = 1;
          pcnt = $urandom % 3;
          if (req_addr == 3'd7) begin
            pdata = st_seq[(stat_rd < st_len) ? stat_rd : st_len - 1];
            if (stat_rd == 0) pcnt = first_lat;
            stat_rd++;
          end else if (mode == 1) pdata = 8'hFF;
          else pdata = dev_reg[req_addr];
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // expected outcome from the status sequence and device mode
  function automatic void expect_of(output bit flt, output bit conf, output int nrd);
    logic [7:0] acc = 8'h00;
    flt = 0; conf = 0; nrd = st_len;
    for (int i = 0; i < st_len; i++) begin
      acc = acc | st_seq[i];
      if (acc == 8'hFF) begin conf = 1; flt = (mode != 0); nrd = i + 1; return; end
      if (!acc[7]) begin nrd = i + 1; return; end
    end
  endfunction

  task automatic prep(input int m);
    mode = m; stat_rd = 0; wr_cnt = 0; done_cnt = 0; first_lat = 0;
    for (int i = 0; i < 8; i++) dev_reg[i] = 8'h00;
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_tick();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  task automatic wait_done(input int lim);
    for (int i = 0; i < lim && done_cnt == 0; i++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic run_check(input string tag);
    bit ef, ec; int en;
    expect_of(ef, ec, en);
    pulse_start();
    wait_done(400);
    check({tag, " R9 done pulses"}, done_cnt, 1);
    check({tag, " R8 floating"}, int'(last_float), int'(ef));
    check({tag, " R3 status reads"}, stat_rd, en);
    check({tag, " R4/R7 writes"}, wr_cnt, ec ? 3 : 0);
    if (ec) begin
      check({tag, " R7 order addr0"}, wr_a[0], 2); check({tag, " R7 data0"}, wr_d[0], 8'hAA);
      check({tag, " R7 order addr1"}, wr_a[1], 3); check({tag, " R7 data1"}, wr_d[1], 8'h55);
      check({tag, " R7 order addr2"}, wr_a[2], 4); check({tag, " R7 data2"}, wr_d[2], 8'hFF);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    check("R1 done at reset", done, 0);
    check("R1 floating at reset", floating, 0);
    check("R1 no request at reset", req_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 no request while idle", req_valid, 0);

    // R4: busy bit low at once
    prep(0); st_seq[0] = 8'h50; st_len = 1;
    run_check("busy_low R4");

    // R8: registers present
    prep(0); st_seq[0] = 8'h80; st_seq[1] = 8'h8F; st_seq[2] = 8'hF0; st_len = 3;
    run_check("present R8");

    // R8: writes ignored, reads all ones
    prep(1); st_seq[0] = 8'hFF; st_len = 1;
    run_check("absent R8");

    // R8: one register stuck
    prep(2); st_seq[0] = 8'hC1; st_seq[1] = 8'hBE; st_len = 2;
    run_check("stuck R8");
    check("R9 floating after done", floating, 1);
    repeat (50) @(negedge clk);
    check("R9 floating held", floating, 1);

    // R6 / R2: window expiry, start during a run ignored
    prep(0); st_seq[0] = 8'h80; st_len = 1;
    pulse_start();
    check("R9 floating cleared by start", floating, 0);
    for (int i = 0; i < W - 1; i++) begin repeat (3) @(negedge clk); pulse_tick(); end
    repeat (5) @(negedge clk);
    pulse_start();
    repeat (100) @(negedge clk);
    check("R6 no verdict before window R2", done_cnt, 0);
    pulse_tick();
    wait_done(50);
    check("R6 verdict after window", done_cnt, 1);
    check("R6 not floating", int'(last_float), 0);
    check("R6 no writes", wr_cnt, 0);
    check("R2 start did not restart", int'(stat_rd > 10), 1);

    // R5: all ones wins over an expired window
    prep(0); st_seq[0] = 8'hFF; st_len = 1; first_lat = 30;
    pulse_start();
    for (int i = 0; i < W + 1; i++) pulse_tick();
    wait_done(400);
    check("R5 confirmation entered", wr_cnt, 3);
    check("R5 not floating", int'(last_float), 0);
    check("R5 one status read", stat_rd, 1);

    // random runs
    for (int r = 0; r < 30; r++) begin
      prep($urandom % 3);
      st_len = 1 + ($urandom % 6);
      for (int i = 0; i < st_len; i++) st_seq[i] = 8'h80 | 8'($urandom);
      if (($urandom % 4) == 0) st_seq[0] = 8'($urandom) & 8'h7F;
      st_seq[st_len - 1] = 8'hFF;
      run_check("random");
    end

    check("R10 request held while stalled", hold_viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule